// File: doc/BRIEF.md
# PRBS7 Built-In Self-Test Pair

This block lets a serial link test itself at full speed. When test mode is on, a pseudorandom generator replaces the encoded transmit word that would feed the serializer. It emits a maximal-length sequence of period 127, ten bits per clock. On the receive side a checker watches the incoming ten-bit words and locks onto the stream from its own first seven bits. It then predicts every later bit from the bits it has already seen and raises a pass flag while every prediction matches.

The pass flag takes over the low-byte K-character indicator output for as long as test mode is on. A loopback select feeds the transmit word straight back into the checker and disables the external serial driver. Test mode together with loopback therefore exercises the whole path with no external equipment. Without loopback, the checker verifies a stream that arrives from a far end.

Top module: `prbs7_bist`

## Requirements
- R1: While reset is held, the generator holds its seed (all seven history bits one) and the checker is unseeded. After reset is released with test mode on, the pass flag reads low until the checker has consumed one received word.
- R2: With `test_en` low, `tx_ser_o` equals `tx_enc_i` in the same cycle.
- R3: With `test_en` high, `tx_ser_o` carries the sequence b[n] = b[n-6] XOR b[n-7] (polynomial x^7 + x^6 + 1). Bit 0 of each word is the earliest bit, and the sequence continues without a gap from one word to the next. The first word after enabling is computed from a history of seven ones.
- R4: Each time `test_en` rises, the generator restarts from its seed, so the first word repeats exactly.
- R5: With `loop_sel` high, `tx_oe_o` is low and the checker takes `tx_ser_o` as its input. With `loop_sel` low, `tx_oe_o` is high and the checker takes `rx_line_i`.
- R6: With `test_en` low, `rx_klo_o` equals `rx_klo_i`.
- R7: With `test_en` high, `rx_klo_o` shows the pass flag, whatever the value of `rx_klo_i`.
- R8: After `test_en` rises, and after a clear, the checker loads its history from the first seven received bits. The flag is low until then. One cycle after the first word, the flag is high if the remaining bits of that word fit the sequence.
- R9: A single mismatched bit drops the flag in the next cycle. The flag then stays low while test mode stays on, even if only correct words follow.
- R10: A cycle with `err_clr` high discards the error and the lock: the flag is low in the next cycle and comes back high one cycle after the next correct word.
- R11: The checker locks onto the sequence at any phase offset. It does not need to be aligned with the local generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en | input | 1 | Turns on generation and checking |
| loop_sel | input | 1 | Internal loopback from transmit word to checker |
| err_clr | input | 1 | Clears the sticky error and restarts checker lock |
| tx_enc_i | input | W | Encoded transmit word in normal operation |
| tx_ser_o | output | W | Word handed to the serializer, bit 0 sent first |
| tx_oe_o | output | 1 | External serial driver enable (low means high impedance) |
| rx_line_i | input | W | Word from the deserializer, bit 0 received first |
| rx_klo_i | input | 1 | Low-byte K-character flag from the decoder |
| rx_klo_o | output | 1 | Low-byte K flag, or the pass flag in test mode |

## Verification
The bench goes after the word boundary of the sequence. A generator that restarts its history in each word, or that sends the bits in reverse order, produces words that differ from the bench's 127-bit table. The bench probes the lock window: a flag that is high before any word arrives, or that ignores errors inside the first word, fails the checks just after enable and just after a clear. It injects single-bit errors at random positions and random phase offsets. A checker that compares against its own generator instead of the received history, or whose error flag is not sticky, fails those checks. Loopback and pass-through are tested with a garbage line input, so a checker that reads the wrong source is exposed.

// File: rtl/prbs7_pkg.sv
// Shared definitions for the PRBS7 self-test pair.
// Assumes polynomial x^7 + x^6 + 1; history bit 0 is the newest bit.
package prbs7_pkg;
    localparam int PRBS_ORDER = 7;
    typedef logic [PRBS_ORDER-1:0] prbs_hist_t;

    // Next bit predicted from a seven-bit history.
    function automatic logic prbs_next(input prbs_hist_t h);
        return h[6] ^ h[5];
    endfunction
endpackage

// File: rtl/prbs7_gen.sv
// PRBS7 word generator: emits W sequence bits per cycle, bit 0 first.
// Holds the seed while reset is low or run is low, so every enable restarts it.
module prbs7_gen
    import prbs7_pkg::*;
#(
    parameter int         W    = 10,
    parameter prbs_hist_t SEED = 7'h7F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] word_o
);
    prbs_hist_t hist_q;
    prbs_hist_t hist_n;

    // Unroll W sequence steps from the current history.
    always_comb begin
        prbs_hist_t h;
        logic       b;
        h      = hist_q;
        word_o = '0;
        for (int i = 0; i < W; i++) begin
            b         = prbs_next(h);
            word_o[i] = b;
            h         = {h[PRBS_ORDER-2:0], b};
        end
        hist_n = h;
    end

    // Advance the history one word per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) hist_q <= SEED;
        else                hist_q <= hist_n;
    end
endmodule

// File: rtl/prbs7_chk.sv
// Self-synchronising PRBS7 checker. The first seven received bits seed the
// history; each later bit is compared with the prediction and then shifted in.
// Assumes the received word arrives with bit 0 earliest.
module prbs7_chk
    import prbs7_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] word_i,
    output logic         locked_o,
    output logic         pass_o
);
    localparam int             CW   = $clog2(PRBS_ORDER + 1);
    localparam logic [CW-1:0]  FULL = CW'(PRBS_ORDER);

    prbs_hist_t    hist_q, hist_n;
    logic [CW-1:0] fill_q, fill_n;
    logic          err_q, bad;

    // Walk the word bit by bit: fill the history first, then compare.
    always_comb begin
        prbs_hist_t    h;
        logic [CW-1:0] c;
        h   = hist_q;
        c   = fill_q;
        bad = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (c == FULL) begin
                if (prbs_next(h) != word_i[i]) bad = 1'b1;
            end else begin
                c = c + 1'b1;
            end
            h = {h[PRBS_ORDER-2:0], word_i[i]};
        end
        hist_n = h;
        fill_n = c;
    end

    // Hold lock state and the sticky error; drop both when idle or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            hist_q <= '0;
            fill_q <= '0;
            err_q  <= 1'b0;
        end else begin
            hist_q <= hist_n;
            fill_q <= fill_n;
            err_q  <= err_q | bad;
        end
    end

    assign locked_o = (fill_q == FULL);
    assign pass_o   = locked_o && !err_q;
endmodule

// File: rtl/prbs7_route.sv
// Path selection around the self-test pair: transmit word choice, loopback
// source for the checker, driver enable, and the shared K/pass output.
module prbs7_route #(
    parameter int W = 10
) (
    input  logic         test_en,
    input  logic         loop_sel,
    input  logic [W-1:0] enc_word,
    input  logic [W-1:0] gen_word,
    input  logic [W-1:0] line_word,
    input  logic         klo_in,
    input  logic         pass_in,
    output logic [W-1:0] ser_word,
    output logic [W-1:0] chk_word,
    output logic         drv_en,
    output logic         klo_out
);
    // Choose the serializer word, then the checker source from it.
    always_comb begin
        ser_word = test_en  ? gen_word : enc_word;
        chk_word = loop_sel ? ser_word : line_word;
        drv_en   = !loop_sel;
        klo_out  = test_en  ? pass_in  : klo_in;
    end
endmodule

// File: rtl/prbs7_bist.sv
// Top of the PRBS7 self-test pair: generator, checker and path routing.
// Assumes W >= PRBS order so one word seeds the checker.
module prbs7_bist
    import prbs7_pkg::*;
#(
    parameter int         W    = 10,
    parameter prbs_hist_t SEED = 7'h7F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_en,
    input  logic         loop_sel,
    input  logic         err_clr,
    input  logic [W-1:0] tx_enc_i,
    output logic [W-1:0] tx_ser_o,
    output logic         tx_oe_o,
    input  logic [W-1:0] rx_line_i,
    input  logic         rx_klo_i,
    output logic         rx_klo_o
);
    logic [W-1:0] gen_word;
    logic [W-1:0] chk_word;
    logic         chk_locked;
    logic         chk_pass;

    prbs7_gen #(.W(W), .SEED(SEED)) u_gen (
        .clk(clk), .rst_n(rst_n), .run(test_en), .word_o(gen_word)
    );

    prbs7_chk #(.W(W)) u_chk (
        .clk(clk), .rst_n(rst_n), .run(test_en), .restart(err_clr),
        .word_i(chk_word), .locked_o(chk_locked), .pass_o(chk_pass)
    );

    prbs7_route #(.W(W)) u_route (
        .test_en(test_en), .loop_sel(loop_sel),
        .enc_word(tx_enc_i), .gen_word(gen_word), .line_word(rx_line_i),
        .klo_in(rx_klo_i), .pass_in(chk_pass),
        .ser_word(tx_ser_o), .chk_word(chk_word),
        .drv_en(tx_oe_o), .klo_out(rx_klo_o)
    );
endmodule

// File: rtl/prbs7_bist_sva.sv
// Property checker for prbs7_bist, attached by bind below.
module prbs7_bist_sva #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         test_en,
    input logic         loop_sel,
    input logic         err_clr,
    input logic [W-1:0] tx_enc_i,
    input logic [W-1:0] tx_ser_o,
    input logic         tx_oe_o,
    input logic         rx_klo_i,
    input logic         rx_klo_o,
    input logic         locked
);
    AST_BYPASS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> tx_ser_o == tx_enc_i); // R2
    AST_KLO_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> rx_klo_o == rx_klo_i); // R6
    AST_LOOP_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        loop_sel |-> !tx_oe_o); // R5
    AST_UNSEEDED_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_en) |-> !rx_klo_o); // R8
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        test_en && locked && !rx_klo_o && !err_clr |=> !test_en || !rx_klo_o); // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        test_en && err_clr |=> !test_en || !rx_klo_o); // R10
    AST_SEQ_ACROSS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        test_en && $past(test_en) && $past(rst_n) |->
            tx_ser_o[0] == ($past(tx_ser_o[W-6]) ^ $past(tx_ser_o[W-7]))); // R3
    generate
        if (W >= 8) begin : g_inword
            AST_SEQ_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
                test_en |-> tx_ser_o[7] == (tx_ser_o[1] ^ tx_ser_o[0])); // R3
        end
    endgenerate
endmodule

bind prbs7_bist prbs7_bist_sva #(.W(W)) u_sva (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .loop_sel(loop_sel),
    .err_clr(err_clr), .tx_enc_i(tx_enc_i), .tx_ser_o(tx_ser_o),
    .tx_oe_o(tx_oe_o), .rx_klo_i(rx_klo_i), .rx_klo_o(rx_klo_o),
    .locked(chk_locked)
);

// File: tb/prbs7_bist_test.sv
`timescale 1ns/1ps
module prbs7_bist_test;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n, test_en, loop_sel, err_clr, rx_klo_i;
    logic [W-1:0] tx_enc_i, rx_line_i;
    logic [W-1:0] tx_ser_o;
    logic         tx_oe_o, rx_klo_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    bit  seq [127];

    always #2.5 clk = ~clk;

    prbs7_bist #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .loop_sel(loop_sel),
        .err_clr(err_clr), .tx_enc_i(tx_enc_i), .tx_ser_o(tx_ser_o),
        .tx_oe_o(tx_oe_o), .rx_line_i(rx_line_i), .rx_klo_i(rx_klo_i),
        .rx_klo_o(rx_klo_o)
    );

    // Sequence word starting at bit index s, bit 0 earliest.
    function automatic logic [W-1:0] seq_word(input int s);
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) w[i] = seq[(s + i) % 127];
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int s;
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        // Reference sequence from a history of seven ones.
        for (int n = 0; n < 127; n++)
            seq[n] = (n >= 7 ? seq[n-7] : 1'b1) ^ (n >= 6 ? seq[n-6] : 1'b1);

        rst_n = 0; test_en = 0; loop_sel = 0; err_clr = 0;
        rx_klo_i = 1; tx_enc_i = 10'h2A5; rx_line_i = '0;
        repeat (3) @(negedge clk);
        #1 check("R1 reset klo pass-through", rx_klo_o, 1);
        check("R5 driver on", tx_oe_o, 1);

        // R1: reset held with test mode on: seed word, flag low.
        test_en = 1; loop_sel = 1;
        @(negedge clk); #1;
        check("R1 seed word in reset", tx_ser_o, seq_word(0));
        check("R1 unseeded in reset", rx_klo_o, 0);
        rst_n = 1; #1;
        check("R1 unseeded after release", rx_klo_o, 0);
        @(negedge clk); #1;
        check("R1 first word after release", tx_ser_o, seq_word(W));
        test_en = 0; loop_sel = 0;

        // R2, R6: bypass with random words.
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            tx_enc_i = W'($urandom); rx_klo_i = 1'($urandom);
            #1 check("R2 bypass word", tx_ser_o, tx_enc_i);
            check("R6 klo pass-through", rx_klo_o, rx_klo_i);
        end

        // R3, R5, R7, R8: loopback self-test, garbage on the line.
        @(negedge clk);
        loop_sel = 1; test_en = 1; rx_klo_i = 1; rx_line_i = 10'h3FF;
        #1 check("R5 driver off in loopback", tx_oe_o, 0);
        check("R3 first word", tx_ser_o, seq_word(0));
        check("R8 unseeded before first word", rx_klo_o, 0);
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            rx_line_i = W'($urandom); rx_klo_i = 1'($urandom);
            #1 check("R3 word stream", tx_ser_o, seq_word((W * k) % 127));
            check("R7 pass in loopback", rx_klo_o, 1);
        end

        // R4: re-enable restarts the generator and the lock.
        @(negedge clk); test_en = 0;
        @(negedge clk); @(negedge clk); test_en = 1;
        #1 check("R4 restart word", tx_ser_o, seq_word(0));
        check("R8 unseeded after re-enable", rx_klo_o, 0);

        // R9, R10, R11: external stream at random phases with injected errors.
        loop_sel = 0;
        for (int t = 0; t < 6; t++) begin
            s = $urandom_range(0, 126);
            @(negedge clk); err_clr = 1; rx_line_i = seq_word(s);
            @(negedge clk); err_clr = 0;
            #1 check("R10 clear drops flag", rx_klo_o, 0);
            #0 check("R5 driver on", tx_oe_o, 1);
            for (int j = 0; j < 3; j++) begin
                rx_line_i = seq_word((s + W * j) % 127);
                @(negedge clk); #1;
                check("R11 lock at random phase", rx_klo_o, 1);
            end
            rx_line_i = seq_word((s + W * 3) % 127);
            rx_line_i[$urandom_range(0, W-1)] ^= 1'b1;
            @(negedge clk); #1;
            check("R9 error drops flag", rx_klo_o, 0);
            for (int j = 4; j < 9; j++) begin
                rx_line_i = seq_word((s + W * j) % 127);
                rx_klo_i = 1;
                @(negedge clk); #1;
                check("R9 error sticky", rx_klo_o, 0);
            end
        end

        // R8: error inside the first word's tail is seen at once.
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        rx_line_i = seq_word(40); rx_line_i[9] ^= 1'b1;
        @(negedge clk); #1;
        check("R8 bad tail of first word", rx_klo_o, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule